// File: doc/BRIEF.md
# Indirect MDIO PHY Command Engine

This block gives a host indirect access to PHY registers over a two-wire management bus. The host sees two 16-bit registers, a command register at offset 0x18 and a data register at offset 0x19. Writing the command register with bit 15 set starts one management frame on either the internal or the external PHY bus. The frame follows either the Clause 22 or the Clause 45 format. The engine produces MDC from the system clock, drives and releases the MDIO line of the chosen bus, and returns read data through the data register. It clears the busy bit when the frame ends.

For a write, and for a Clause 45 address-write, the host first loads the payload into the data register and then issues the command. For a read, the host polls until busy reads 0 and then reads the data register. A Clause 45 register access therefore takes two commands. The first is an address-write that carries the 16-bit register address in the data register. The second is a data read or data write to the same port and device class.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, busy reads 0 and the data register reads 0x0000. Both MDC outputs are low, both MDIO output enables are low, and both MDIO outputs are high.
- R2: A write to offset 0x18 with bit 15 set is taken only while busy is 0, and it stores bits 14:0 as the command. The write is ignored when busy is 1, and it is also ignored when bit 15 is 0.
- R3: Command bits 14:13 choose the bus: 00 selects the internal bus and 01 selects the external bus. Only the chosen bus toggles MDC or enables MDIO during the frame.
- R4: Some commands raise no frame and leave busy at 0. These are function 10 (setup), function 11, and a Clause 22 command whose opcode is 00 or 11. Bits 14:0 of such a command are still stored.
- R5: A frame is 64 bits, sent most significant first:
  - 32 ones of preamble;
  - a start code, 01 when bit 12 is 1 (Clause 22) and 00 when bit 12 is 0 (Clause 45);
  - opcode bits 11:10 as sent;
  - bits 9:5, then bits 4:0;
  - two turnaround bits;
  - 16 data bits.
- R6: Write frames and Clause 45 address frames drive turnaround 10. They then send the value the data register held when the command was taken.
- R7: Read frames release MDIO, with output enable low, for the two turnaround bits and the 16 data bits. A read frame is Clause 22 opcode 10 or Clause 45 opcode 10 or 11. The engine samples the 16 data bits, most significant first, before each MDC rising edge. It writes them into the data register in the same cycle that busy clears.
- R8: MDC has a period of 2*MDC_HALF system clocks and starts low. Each bit lasts one MDC period, so busy stays high for 64*2*MDC_HALF cycles. MDIO changes only when MDC falls, except for the first bit, which is driven as the frame starts.
- R9: Writes to offset 0x19 are ignored while busy is 1. This includes a write in the last cycle of a frame.
- R10: Reading offset 0x18 returns {busy, stored command bits 14:0}. Reading offset 0x19 returns the data register. Reading any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| mdc_int | output | 1 | Internal bus management clock |
| mdio_int_o | output | 1 | Internal bus MDIO output value |
| mdio_int_oe | output | 1 | Internal bus MDIO output enable |
| mdio_int_i | input | 1 | Internal bus MDIO input |
| mdc_ext | output | 1 | External bus management clock |
| mdio_ext_o | output | 1 | External bus MDIO output value |
| mdio_ext_oe | output | 1 | External bus MDIO output enable |
| mdio_ext_i | input | 1 | External bus MDIO input |

## Verification
Two events can fall in the same clock edge. One is the end of a frame, which clears busy and loads captured read data. The other is a host write to the data register or to the command register. The bench waits for the last cycle of a read frame and writes the data register in exactly that cycle. The data register must then hold the read value and not the written one. The bench then issues a new command in the very first idle cycle, and that command must start a frame immediately. A per-clock reference model judges MDC, MDIO and output enable on both buses throughout.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int WORD_W     = 16;
  localparam int ADDR5_W    = 5;

  typedef enum logic [1:0] {
    FN_INT   = 2'b00,
    FN_EXT   = 2'b01,
    FN_SETUP = 2'b10,
    FN_RSVD  = 2'b11
  } fn_e;

  typedef struct packed {
    logic [1:0]         fn;
    logic               c22;
    logic [1:0]         op;
    logic [ADDR5_W-1:0] dev;
    logic [ADDR5_W-1:0] rg;
  } cmd_t;

  function automatic logic cmd_runs_frame(input cmd_t c);
    logic fn_ok;
    fn_ok = (c.fn == FN_INT) || (c.fn == FN_EXT);
    if (c.c22) return fn_ok && (c.op == 2'b01 || c.op == 2'b10);
    return fn_ok;
  endfunction

  function automatic logic cmd_is_read(input cmd_t c);
    if (c.c22) return c.op == 2'b10;
    return c.op[1];
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input cmd_t c,
                                                        input logic [WORD_W-1:0] d);
    logic [1:0]        st;
    logic [1:0]        ta;
    logic [WORD_W-1:0] pay;
    st  = c.c22 ? 2'b01 : 2'b00;
    ta  = cmd_is_read(c) ? 2'b11 : 2'b10;
    pay = cmd_is_read(c) ? {WORD_W{1'b1}} : d;
    return {{PRE_BITS{1'b1}}, st, c.op, c.dev, c.rg, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             wrap;

  assign wrap      = run && (cnt == LAST);
  assign rise_tick = wrap && !phase;
  assign fall_tick = wrap && phase;
  assign mdc       = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int FBITS = 64,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FBITS-1:0] frame_in,
  input  logic             is_read,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [DW-1:0]    rd_word
);
  localparam int IDX_W = $clog2(FBITS);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FBITS - 1);
  localparam logic [IDX_W-1:0] DATA_START = IDX_W'(FBITS - DW);
  localparam logic [IDX_W-1:0] TA_START   = IDX_W'(FBITS - DW - 2);

  logic [FBITS-1:0] frame_q;
  logic             rd_q;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    shreg;

  assign done    = fall_tick && (idx == LAST_IDX);
  assign mdio_o  = frame_q[LAST_IDX - idx];
  assign mdio_oe = !(rd_q && (idx >= TA_START));
  assign rd_word = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= {FBITS{1'b1}};
      rd_q    <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
    end else if (start) begin
      frame_q <= frame_in;
      rd_q    <= is_read;
      idx     <= '0;
    end else begin
      if (fall_tick) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      if (rise_tick && rd_q && idx >= DATA_START) shreg <= {shreg[DW-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h18,
  parameter logic [ADDR_W-1:0] DATA_OFS = 5'h19,
  parameter int                MDC_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              mdc_int,
  output logic              mdio_int_o,
  output logic              mdio_int_oe,
  input  logic              mdio_int_i,
  output logic              mdc_ext,
  output logic              mdio_ext_o,
  output logic              mdio_ext_oe,
  input  logic              mdio_ext_i
);
  localparam int NBUS = 2;

  logic              busy;
  cmd_t              cmd_q;
  logic [WORD_W-1:0] data_q;
  logic              sel_q;
  cmd_t              cmd_in;
  logic              cmd_req;
  logic              frame_start;
  logic              frame_done;
  logic              data_wr_ok;
  logic              mdc_raw, rise_tick, fall_tick;
  logic              sh_o, sh_oe, sh_i;
  logic [WORD_W-1:0] rd_word;
  logic [NBUS-1:0]   bus_mdc, bus_o, bus_oe, bus_i;

  assign cmd_in      = cmd_t'(host_wdata[14:0]);
  assign cmd_req     = host_wr && (host_addr == CMD_OFS) && host_wdata[15] && !busy;
  assign frame_start = cmd_req && cmd_runs_frame(cmd_in);
  assign data_wr_ok  = host_wr && (host_addr == DATA_OFS) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (cmd_req) cmd_q <= cmd_in;
      if (frame_start) begin
        busy  <= 1'b1;
        sel_q <= cmd_in.fn[0];
      end else if (frame_done) begin
        busy <= 1'b0;
      end
      if (data_wr_ok) data_q <= host_wdata;
      else if (frame_done && cmd_is_read(cmd_q)) data_q <= rd_word;
    end
  end

  always_comb begin
    if (host_addr == CMD_OFS)       host_rdata = {busy, cmd_q};
    else if (host_addr == DATA_OFS) host_rdata = data_q;
    else                            host_rdata = '0;
  end

  mdio_clk_div #(.HALF(MDC_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc_raw),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_shifter #(.FBITS(FRAME_BITS), .DW(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .frame_in  (build_frame(cmd_in, data_q)),
    .is_read   (cmd_is_read(cmd_in)),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (sh_i),
    .mdio_o    (sh_o),
    .mdio_oe   (sh_oe),
    .done      (frame_done),
    .rd_word   (rd_word)
  );

  assign bus_i = {mdio_ext_i, mdio_int_i};
  assign sh_i  = bus_i[sel_q];

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic own;
    assign own        = busy && (sel_q == b[0]);
    assign bus_mdc[b] = own && mdc_raw;
    assign bus_oe[b]  = own && sh_oe;
    assign bus_o[b]   = own ? sh_o : 1'b1;
  end

  assign mdc_int     = bus_mdc[0];
  assign mdio_int_o  = bus_o[0];
  assign mdio_int_oe = bus_oe[0];
  assign mdc_ext     = bus_mdc[1];
  assign mdio_ext_o  = bus_o[1];
  assign mdio_ext_oe = bus_oe[1];
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        frame_start,
  input logic        frame_done,
  input logic [14:0] cmd_q,
  input logic [15:0] data_q,
  input logic        mdc_int,
  input logic        mdc_ext,
  input logic        mdio_int_o,
  input logic        mdio_ext_o,
  input logic        mdio_int_oe,
  input logic        mdio_ext_oe
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> busy);

  p_cmd_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> $stable(cmd_q));

  p_one_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdc_int && mdc_ext) && !(mdio_int_oe && mdio_ext_oe));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc_int && !mdc_ext && !mdio_int_oe && !mdio_ext_oe));

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  p_int_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_int && $past(mdc_int)) |-> $stable(mdio_int_o));

  p_ext_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_ext && $past(mdc_ext)) |-> $stable(mdio_ext_o));

  p_data_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> $stable(data_q));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .cmd_q       (cmd_q),
  .data_q      (data_q),
  .mdc_int     (mdc_int),
  .mdc_ext     (mdc_ext),
  .mdio_int_o  (mdio_int_o),
  .mdio_ext_o  (mdio_ext_o),
  .mdio_int_oe (mdio_int_oe),
  .mdio_ext_oe (mdio_ext_oe)
);

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int H   = 3;
  localparam int P   = 2 * H;
  localparam int FCY = 64 * P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = 5'h0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        mdc_int, mdio_int_o, mdio_int_oe, mdio_int_i;
  logic        mdc_ext, mdio_ext_o, mdio_ext_oe, mdio_ext_i;

  int tests = 0;
  int fails = 0;
  int shown = 0;

  always #10 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc_int(mdc_int), .mdio_int_o(mdio_int_o), .mdio_int_oe(mdio_int_oe), .mdio_int_i(mdio_int_i),
    .mdc_ext(mdc_ext), .mdio_ext_o(mdio_ext_o), .mdio_ext_oe(mdio_ext_oe), .mdio_ext_i(mdio_ext_i)
  );

  // Reference model state
  logic        m_busy;
  int          m_t;
  logic [63:0] m_frame;
  logic        m_rd;
  logic        m_sel;
  logic [15:0] m_data;
  logic [14:0] m_cmd;
  logic [15:0] phy_val = 16'h0;

  function automatic logic ref_runs(input logic [15:0] w);
    if (w[14]) return 1'b0;
    if (w[12]) return (w[11:10] == 2'b01) || (w[11:10] == 2'b10);
    return 1'b1;
  endfunction

  function automatic logic ref_read(input logic [15:0] w);
    return w[12] ? (w[11:10] == 2'b10) : (w[11:10] >= 2'b10);
  endfunction

  function automatic logic [63:0] ref_frame(input logic [15:0] w, input logic [15:0] d);
    logic [63:0] f;
    f = 64'h0;
    for (int i = 0; i < 32; i++) f = (f << 1) | 64'd1;
    f = (f << 2) | (w[12] ? 64'd1 : 64'd0);
    f = (f << 2) | 64'(w[11:10]);
    f = (f << 5) | 64'(w[9:5]);
    f = (f << 5) | 64'(w[4:0]);
    f = (f << 2) | (ref_read(w) ? 64'd3 : 64'd2);
    f = (f << 16) | (ref_read(w) ? 64'hFFFF : 64'(d));
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_t <= 0; m_frame <= '1; m_rd <= 1'b0;
      m_sel <= 1'b0; m_data <= 16'h0; m_cmd <= 15'h0;
    end else begin
      if (m_busy) begin
        if (m_t == FCY - 1) begin
          m_busy <= 1'b0;
          if (m_rd) m_data <= phy_val;
        end else m_t <= m_t + 1;
      end else if (host_wr && host_addr == 5'h18 && host_wdata[15]) begin
        m_cmd <= host_wdata[14:0];
        if (ref_runs(host_wdata)) begin
          m_busy  <= 1'b1;
          m_t     <= 0;
          m_frame <= ref_frame(host_wdata, m_data);
          m_rd    <= ref_read(host_wdata);
          m_sel   <= host_wdata[13];
        end
      end
      if (!m_busy && host_wr && host_addr == 5'h19) m_data <= host_wdata;
    end
  end

  // PHY side: drives read data for the whole bit period
  logic phy_bit;
  assign phy_bit    = (m_busy && (m_t / P) >= 48) ? phy_val[63 - (m_t / P)] : 1'b1;
  assign mdio_int_i = (m_busy && !m_sel) ? phy_bit : 1'b1;
  assign mdio_ext_i = (m_busy && m_sel) ? phy_bit : 1'b1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (shown < 20) $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      shown++;
    end
  endtask

  // Per-clock comparison of the bus pins against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic em, eo;
      logic [5:0] act, exp;
      em = m_busy && ((m_t % P) >= H);
      eo = m_busy && !(m_rd && (m_t / P) >= 46);
      exp[0] = em && !m_sel;  exp[1] = em && m_sel;
      exp[2] = eo && !m_sel;  exp[3] = eo && m_sel;
      exp[4] = (eo && !m_sel) ? m_frame[63 - (m_t / P)] : ((m_busy && !m_sel) ? mdio_int_o : 1'b1);
      exp[5] = (eo && m_sel)  ? m_frame[63 - (m_t / P)] : ((m_busy && m_sel) ? mdio_ext_o : 1'b1);
      act = {mdio_ext_o, mdio_int_o, mdio_ext_oe, mdio_int_oe, mdc_ext, mdc_int};
      check("R3 R5 R8 bus pins", {10'h0, act}, {10'h0, exp});
    end
  end

  task automatic hwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < FCY + 50; i++) begin
      hread(5'h18, v);
      if (!v[15]) return;
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] fn, input logic c22,
                                     input logic [1:0] op, input logic [4:0] dv,
                                     input logic [4:0] rg);
    return {1'b1, fn, c22, op, dv, rg};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    hread(5'h18, v); check("R1 cmd/busy", v, 16'h0000);
    hread(5'h19, v); check("R1 data", v, 16'h0000);
    check("R1 pins", {10'h0, mdc_int, mdc_ext, mdio_int_oe, mdio_ext_oe, mdio_int_o, mdio_ext_o},
          16'h0003);
    // R10 other offset
    hwrite(5'h19, 16'hBEEF);
    hread(5'h07, v); check("R10 other offset", v, 16'h0000);
    hread(5'h19, v); check("R10 data readback", v, 16'hBEEF);

    // R6 Clause 22 write, internal bus
    hwrite(5'h19, 16'hA5C3);
    c = mk(2'b00, 1'b1, 2'b01, 5'h11, 5'h0A);
    hwrite(5'h18, c);
    hread(5'h18, v); check("R2 busy set", v, c);
    // R2 command write while busy ignored; R9 data write while busy ignored
    hwrite(5'h18, mk(2'b01, 1'b1, 2'b10, 5'h03, 5'h04));
    hwrite(5'h19, 16'h1111);
    hread(5'h18, v); check("R2 cmd ignored while busy", v, c);
    hread(5'h19, v); check("R9 data ignored while busy", v, 16'hA5C3);
    wait_idle();
    hread(5'h18, v); check("R8 busy cleared", v, {1'b0, c[14:0]});
    hread(5'h19, v); check("R6 data kept after write", v, 16'hA5C3);

    // R7 Clause 22 read, external bus
    phy_val = 16'h3C96;
    hwrite(5'h18, mk(2'b01, 1'b1, 2'b10, 5'h1F, 5'h01));
    wait_idle();
    hread(5'h19, v); check("R7 c22 read data", v, 16'h3C96);

    // Clause 45: address-write, read, read-increment, write
    hwrite(5'h19, 16'h8001);
    hwrite(5'h18, mk(2'b01, 1'b0, 2'b00, 5'h02, 5'h07));
    wait_idle();
    hread(5'h19, v); check("R6 c45 addr data kept", v, 16'h8001);
    phy_val = 16'h0F0E;
    hwrite(5'h18, mk(2'b01, 1'b0, 2'b11, 5'h02, 5'h07));
    wait_idle();
    hread(5'h19, v); check("R7 c45 read", v, 16'h0F0E);
    phy_val = 16'hF00D;
    hwrite(5'h18, mk(2'b00, 1'b0, 2'b10, 5'h05, 5'h1E));
    wait_idle();
    hread(5'h19, v); check("R7 c45 read-inc", v, 16'hF00D);
    hwrite(5'h19, 16'h5A5A);
    hwrite(5'h18, mk(2'b00, 1'b0, 2'b01, 5'h05, 5'h1E));
    wait_idle();

    // R4 setup function and invalid opcodes: no frame
    c = mk(2'b10, 1'b1, 2'b01, 5'h0C, 5'h13);
    hwrite(5'h18, c);
    hread(5'h18, v); check("R4 setup no busy", v, {1'b0, c[14:0]});
    c = mk(2'b00, 1'b1, 2'b00, 5'h01, 5'h02);
    hwrite(5'h18, c);
    hread(5'h18, v); check("R4 c22 op00 no busy", v, {1'b0, c[14:0]});
    c = mk(2'b11, 1'b0, 2'b11, 5'h01, 5'h02);
    hwrite(5'h18, c);
    hread(5'h18, v); check("R4 function 11 no busy", v, {1'b0, c[14:0]});
    // R2 bit 15 clear: ignored
    hwrite(5'h18, 16'h1234);
    hread(5'h18, v); check("R2 no start bit ignored", v, {1'b0, c[14:0]});

    // Same-cycle: data write in the last frame cycle, then command at once
    phy_val = 16'hC0DE;
    hwrite(5'h18, mk(2'b00, 1'b1, 2'b10, 5'h04, 5'h09));
    while (!(m_busy && m_t == FCY - 1)) @(negedge clk);
    host_wr = 1'b1; host_addr = 5'h19; host_wdata = 16'h7777;
    @(negedge clk);
    host_addr = 5'h18; host_wdata = mk(2'b01, 1'b1, 2'b01, 5'h06, 5'h02);
    @(negedge clk);
    host_wr = 1'b0;
    hread(5'h18, v); check("R2 command in first idle cycle", {15'h0, v[15]}, 16'h0001);
    hread(5'h19, v); check("R9 end-cycle data write ignored", v, 16'hC0DE);
    wait_idle();
    hread(5'h19, v); check("R7 data after back-to-back", v, 16'hC0DE);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule